// File: doc/BRIEF.md
# Machine Timer Interrupt and Trap Entry Unit

This unit sits beside the control path of a small 32-bit core. It runs the machine-mode timer, and it decides at each instruction boundary whether the core must divert into the timer trap handler. It holds a free-running cycle counter, a compare value and a latched timer-pending flag. It also holds the small set of machine state registers that a timer trap touches: the global enable with its saved copy, the timer enable, the exception PC, the cause and the trap vector base.

Software reaches all of these registers through a plain CSR port. A write happens on any cycle with write-enable high, and the read data follows the address combinationally. The core raises `boundary` between instructions. In that same cycle the unit reports which one action applies. A debug halt request comes first, then a completed single step, then the timer trap, and otherwise the core simply fetches the next instruction. When the trap is taken, or when the core signals a trap-return, the unit updates its state on the next clock edge and drives a redirect target for the fetch unit. The timer-pending flag survives both the trap and the return. Only a write to the compare register clears it.

Top module: `mtimer_trap_unit`

## Requirements
- R1: The 32-bit time counter resets to 0 and increases by one on every clock. It reads at CSR address 0x7C0, and writes to that address have no effect.
- R2: The pending flag becomes set one clock after a cycle in which the time counter equals the compare register (address 0x7C1) while status bit 3 (global enable) and enable-register bit 7 (timer enable) are both 1. Without both enables, an equal count leaves it clear.
- R3: Once set, the pending flag stays set until software writes the compare register. Taking the trap does not clear it, and neither does a trap-return. It reads as bit 7 of the pending register at 0x344, which is read-only.
- R4: On trap entry, status bit 7 (saved enable) receives the old status bit 3, status bit 3 becomes 0, and the exception PC (0x341) captures `cur_pc`.
- R5: `act_trap` is high, in the same cycle as `boundary`, exactly when pending, timer enable and global enable are all 1, no halt or step request is present and `ret_req` is low. It lasts one cycle for a one-cycle boundary.
- R6: At a boundary, a halt request wins over a step completion, and a step completion wins over the timer trap. At most one of `act_halt`, `act_step`, `act_trap` is high.
- R7: A taken trap writes 0x80000007 into the cause register (0x342): bit 31 marks an interrupt, and the low byte is the timer code 7.
- R8: On trap entry the redirect target is the trap vector (0x305) with bits 1:0 forced to zero, and `redirect_valid` is high.
- R9: On `ret_req`, status bit 3 takes status bit 7 and status bit 7 becomes 1. In the same cycle `redirect_valid` is high and `redirect_pc` equals the exception PC.
- R10: After reset, status, enable, exception PC, cause, vector and pending read 0 and the compare register reads 0xFFFFFFFF. Status keeps only bits 3 and 7, and the enable register keeps only bit 7. An unmapped address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | CSR write enable |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| boundary | input | 1 | Instruction boundary, decision cycle |
| cur_pc | input | 32 | PC of the instruction about to be interrupted |
| halt_req | input | 1 | Debug halt request |
| step_done | input | 1 | Single-step completed |
| ret_req | input | 1 | Trap-return being executed |
| act_halt | output | 1 | Boundary resolves to halt |
| act_step | output | 1 | Boundary resolves to step stop |
| act_trap | output | 1 | Timer trap taken this cycle |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | 32 | Redirect target |

## Verification
The bench sweeps all four combinations of the two enables through a compare match, so a design that ignores either enable would post an interrupt it should not. It steps through the halt and step combinations while a timer interrupt is ready. A design with the wrong priority would raise the trap, or raise two actions at once. After the trap and again after the return it reads the pending register and writes it directly. A design that clears the flag on trap entry, on return, or on a stray pending-register write would show a zero there, while one that never clears it would still show it set after the compare write. The vector is programmed with its low bits set, so a design that does not mask them would redirect to an odd address.

// File: rtl/mtt_pkg.sv
// Package: shared constants for the machine timer/trap unit.
// Assumes a 32-bit datapath and 12-bit CSR addresses.
package mtt_pkg;
    localparam int XLEN   = 32;
    localparam int AWIDTH = 12;

    localparam logic [AWIDTH-1:0] A_STATUS = 12'h300;
    localparam logic [AWIDTH-1:0] A_ENABLE = 12'h304;
    localparam logic [AWIDTH-1:0] A_VECTOR = 12'h305;
    localparam logic [AWIDTH-1:0] A_EPC    = 12'h341;
    localparam logic [AWIDTH-1:0] A_CAUSE  = 12'h342;
    localparam logic [AWIDTH-1:0] A_PEND   = 12'h344;
    localparam logic [AWIDTH-1:0] A_TIME   = 12'h7C0;
    localparam logic [AWIDTH-1:0] A_CMP    = 12'h7C1;

    localparam int GIE_BIT  = 3;
    localparam int SGIE_BIT = 7;
    localparam int TIE_BIT  = 7;

    localparam logic [XLEN-1:0] TIMER_CAUSE = 32'h8000_0007;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_HALT = 2'd1,
        ACT_STEP = 2'd2,
        ACT_TRAP = 2'd3
    } act_e;
endpackage

// File: rtl/mtt_timer.sv
// Module: free-running time counter, compare register and latched
// pending flag. Assumes cmp_we is already decoded for the compare address.
module mtt_timer #(
    parameter int          W       = 32,
    parameter logic [W-1:0] CMP_RST = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         arm,
    output logic [W-1:0] time_q,
    output logic [W-1:0] cmp_q,
    output logic         pend_q
);
    // Purpose: count every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) time_q <= '0;
        else        time_q <= time_q + 1'b1;
    end

    // Purpose: hold the software compare value.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= CMP_RST;
        else if (cmp_we) cmp_q <= cmp_wdata;
    end

    // Purpose: post on match while armed, clear only on compare write.
    always_ff @(posedge clk) begin
        if (!rst_n)                        pend_q <= 1'b0;
        else if (cmp_we)                   pend_q <= 1'b0;
        else if (arm && (time_q == cmp_q)) pend_q <= 1'b1;
    end

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> time_q == $past(time_q) + 1'b1); // R1
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !cmp_we) |=> pend_q); // R3
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> !pend_q); // R3
endmodule

// File: rtl/mtt_arbiter.sv
// Module: boundary decision between halt, step and timer trap.
// Assumes all request inputs are valid in the boundary cycle.
module mtt_arbiter (
    input  logic         boundary,
    input  logic         halt_req,
    input  logic         step_done,
    input  logic         ret_req,
    input  logic         irq_ready,
    output mtt_pkg::act_e act
);
    import mtt_pkg::*;

    // Purpose: fixed-priority choice of the boundary action.
    always_comb begin
        act = ACT_NONE;
        if (boundary) begin
            if (halt_req)                   act = ACT_HALT;
            else if (step_done)             act = ACT_STEP;
            else if (irq_ready && !ret_req) act = ACT_TRAP;
        end
    end
endmodule

// File: rtl/mtt_state_regs.sv
// Module: status, timer enable, exception PC, cause and vector registers.
// Assumes trap_take and ret_take are exclusive; hardware updates beat
// software writes in the same cycle.
module mtt_state_regs (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       csr_we,
    input  logic [mtt_pkg::AWIDTH-1:0] csr_addr,
    input  logic [mtt_pkg::XLEN-1:0]   csr_wdata,
    input  logic                       trap_take,
    input  logic                       ret_take,
    input  logic [mtt_pkg::XLEN-1:0]   cur_pc,
    output logic                       gie_q,
    output logic                       sgie_q,
    output logic                       tie_q,
    output logic [mtt_pkg::XLEN-1:0]   epc_q,
    output logic [mtt_pkg::XLEN-1:0]   cause_q,
    output logic [mtt_pkg::XLEN-1:0]   vec_q
);
    import mtt_pkg::*;

    logic wr_status, wr_enable, wr_epc, wr_cause, wr_vec;
    assign wr_status = csr_we && (csr_addr == A_STATUS);
    assign wr_enable = csr_we && (csr_addr == A_ENABLE);
    assign wr_epc    = csr_we && (csr_addr == A_EPC);
    assign wr_cause  = csr_we && (csr_addr == A_CAUSE);
    assign wr_vec    = csr_we && (csr_addr == A_VECTOR);

    // Purpose: global enable and its saved copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q  <= 1'b0;
            sgie_q <= 1'b0;
        end else if (trap_take) begin
            sgie_q <= gie_q;
            gie_q  <= 1'b0;
        end else if (ret_take) begin
            gie_q  <= sgie_q;
            sgie_q <= 1'b1;
        end else if (wr_status) begin
            gie_q  <= csr_wdata[GIE_BIT];
            sgie_q <= csr_wdata[SGIE_BIT];
        end
    end

    // Purpose: timer interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)         tie_q <= 1'b0;
        else if (wr_enable) tie_q <= csr_wdata[TIE_BIT];
    end

    // Purpose: exception PC and cause capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (trap_take) begin
            epc_q   <= cur_pc;
            cause_q <= TIMER_CAUSE;
        end else begin
            if (wr_epc)   epc_q   <= csr_wdata;
            if (wr_cause) cause_q <= csr_wdata;
        end
    end

    // Purpose: trap vector base.
    always_ff @(posedge clk) begin
        if (!rst_n)      vec_q <= '0;
        else if (wr_vec) vec_q <= csr_wdata;
    end

    AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (!gie_q && sgie_q == $past(gie_q))); // R4
    AST_ENTRY_EPC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> epc_q == $past(cur_pc)); // R4
    AST_ENTRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> cause_q == TIMER_CAUSE); // R7
    AST_RET_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ret_take |=> (sgie_q && gie_q == $past(sgie_q))); // R9
endmodule

// File: rtl/mtimer_trap_unit.sv
// Module: top of the machine timer interrupt and trap entry unit.
// Assumes boundary and ret_req are single-cycle strobes from the core and
// that the core follows redirect_pc whenever redirect_valid is high.
module mtimer_trap_unit #(
    parameter logic [31:0] CMP_RESET = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_we,
    input  logic [11:0] csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    input  logic        boundary,
    input  logic [31:0] cur_pc,
    input  logic        halt_req,
    input  logic        step_done,
    input  logic        ret_req,
    output logic        act_halt,
    output logic        act_step,
    output logic        act_trap,
    output logic        redirect_valid,
    output logic [31:0] redirect_pc
);
    import mtt_pkg::*;

    logic [XLEN-1:0] time_q, cmp_q, epc_q, cause_q, vec_q;
    logic            pend_q, gie_q, sgie_q, tie_q;
    logic            cmp_we;
    act_e            act;

    assign cmp_we = csr_we && (csr_addr == A_CMP);

    mtt_timer #(.W(XLEN), .CMP_RST(CMP_RESET)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_we    (cmp_we),
        .cmp_wdata (csr_wdata),
        .arm       (gie_q && tie_q),
        .time_q    (time_q),
        .cmp_q     (cmp_q),
        .pend_q    (pend_q)
    );

    mtt_arbiter u_arb (
        .boundary  (boundary),
        .halt_req  (halt_req),
        .step_done (step_done),
        .ret_req   (ret_req),
        .irq_ready (pend_q && tie_q && gie_q),
        .act       (act)
    );

    assign act_halt = (act == ACT_HALT);
    assign act_step = (act == ACT_STEP);
    assign act_trap = (act == ACT_TRAP);

    mtt_state_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .trap_take (act_trap),
        .ret_take  (ret_req),
        .cur_pc    (cur_pc),
        .gie_q     (gie_q),
        .sgie_q    (sgie_q),
        .tie_q     (tie_q),
        .epc_q     (epc_q),
        .cause_q   (cause_q),
        .vec_q     (vec_q)
    );

    // Purpose: redirect target for trap entry or return.
    always_comb begin
        redirect_valid = act_trap || ret_req;
        redirect_pc    = '0;
        if (act_trap)     redirect_pc = {vec_q[XLEN-1:2], 2'b00};
        else if (ret_req) redirect_pc = epc_q;
    end

    // Purpose: combinational CSR read mux, unmapped reads zero.
    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            A_STATUS: begin
                csr_rdata[GIE_BIT]  = gie_q;
                csr_rdata[SGIE_BIT] = sgie_q;
            end
            A_ENABLE: csr_rdata[TIE_BIT] = tie_q;
            A_PEND:   csr_rdata[TIE_BIT] = pend_q;
            A_VECTOR: csr_rdata = vec_q;
            A_EPC:    csr_rdata = epc_q;
            A_CAUSE:  csr_rdata = cause_q;
            A_TIME:   csr_rdata = time_q;
            A_CMP:    csr_rdata = cmp_q;
            default:  csr_rdata = '0;
        endcase
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_halt, act_step, act_trap})); // R6
    AST_TRAP_MASKS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        act_trap |=> !gie_q); // R5
    AST_TRAP_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (act_trap && !cmp_we) |=> pend_q); // R3
    AST_VECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        act_trap |-> redirect_pc[1:0] == 2'b00); // R8
endmodule

// File: tb/mtimer_trap_unit_tb.sv
module mtimer_trap_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        boundary = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        halt_req = 1'b0;
    logic        step_done = 1'b0;
    logic        ret_req = 1'b0;
    logic        act_halt, act_step, act_trap, redirect_valid;
    logic [31:0] redirect_pc;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mtimer_trap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .boundary(boundary),
        .cur_pc(cur_pc), .halt_req(halt_req), .step_done(step_done),
        .ret_req(ret_req), .act_halt(act_halt), .act_step(act_step),
        .act_trap(act_trap), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Boundary strobe: returns {halt,step,trap,valid} and target.
    task automatic strobe(input logic h, input logic s, input logic [31:0] pc,
                          output logic [3:0] acts, output logic [31:0] tgt);
        @(negedge clk);
        boundary = 1'b1; halt_req = h; step_done = s; cur_pc = pc;
        #1 acts = {act_halt, act_step, act_trap, redirect_valid};
        tgt = redirect_pc;
        @(negedge clk);
        boundary = 1'b0; halt_req = 1'b0; step_done = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, t1, t2;
        logic [3:0]  a;
        logic [31:0] tgt;
        idle(3);
        rst_n = 1'b1;

        // R10 reset values
        rd(12'h300, v); check("R10 status reset", v, 0);
        rd(12'h304, v); check("R10 enable reset", v, 0);
        rd(12'h341, v); check("R10 epc reset", v, 0);
        rd(12'h342, v); check("R10 cause reset", v, 0);
        rd(12'h305, v); check("R10 vector reset", v, 0);
        rd(12'h344, v); check("R10 pending reset", v, 0);
        rd(12'h7C1, v); check("R10 compare reset", v, 32'hFFFF_FFFF);

        // R10 unmapped, field masks
        wr(12'h123, 32'hFFFF_FFFF);
        rd(12'h123, v); check("R10 unmapped", v, 0);
        wr(12'h304, 32'hFFFF_FFFF);
        rd(12'h304, v); check("R10 enable mask", v, 32'h80);
        wr(12'h304, 0);
        wr(12'h300, 32'hFFFF_FFFF);
        rd(12'h300, v); check("R10 status mask", v, 32'h88);
        wr(12'h300, 0);

        // R1 counter
        rd(12'h7C0, t1); idle(9); rd(12'h7C0, t2);
        check("R1 time step", t2 - t1, 10);
        wr(12'h7C0, 0);
        rd(12'h7C0, t2);
        check("R1 time write ignored", (t2 - t1 > 10) ? 1 : 0, 1);

        wr(12'h305, 32'h0000_8001);

        // R2 enable sweep through a compare match
        for (int e = 0; e < 4; e++) begin
            wr(12'h300, e[0] ? 32'h8 : 32'h0);
            wr(12'h304, e[1] ? 32'h80 : 32'h0);
            rd(12'h7C0, t1);
            wr(12'h7C1, t1 + 12);
            rd(12'h344, v); check("R2 no early post", v, 0);
            idle(25);
            rd(12'h344, v); check("R2 enable gating", v, (e == 3) ? 32'h80 : 32'h0);
        end

        // R6 priority with a ready interrupt
        strobe(1, 0, 32'h10, a, tgt); check("R6 halt only", {28'd0, a}, 4'b1000);
        strobe(0, 1, 32'h10, a, tgt); check("R6 step only", {28'd0, a}, 4'b0100);
        strobe(1, 1, 32'h10, a, tgt); check("R6 halt over step", {28'd0, a}, 4'b1000);

        // R5 R8 trap entry
        strobe(0, 0, 32'h1234, a, tgt);
        check("R5 trap taken", {28'd0, a}, 4'b0011);
        check("R8 trap target", tgt, 32'h8000);
        rd(12'h300, v); check("R4 status after trap", v, 32'h80);
        rd(12'h341, v); check("R4 epc capture", v, 32'h1234);
        rd(12'h342, v); check("R7 cause", v, 32'h8000_0007);
        rd(12'h344, v); check("R3 pending after trap", v, 32'h80);

        // R5 global enable now clear
        strobe(0, 0, 32'h20, a, tgt); check("R5 masked by status", {28'd0, a}, 0);

        // R9 return
        @(negedge clk); ret_req = 1'b1;
        #1 check("R9 ret valid", {31'd0, redirect_valid}, 1);
        check("R9 ret target", redirect_pc, 32'h1234);
        @(negedge clk); ret_req = 1'b0;
        rd(12'h300, v); check("R9 status after ret", v, 32'h88);
        rd(12'h344, v); check("R3 pending after ret", v, 32'h80);
        wr(12'h344, 0);
        rd(12'h344, v); check("R3 pending write ignored", v, 32'h80);

        // R5 timer enable off
        wr(12'h304, 0);
        strobe(0, 0, 32'h30, a, tgt); check("R5 masked by enable", {28'd0, a}, 0);
        wr(12'h304, 32'h80);

        // R3 compare write clears
        rd(12'h7C0, t1);
        wr(12'h7C1, t1 + 32'h10000);
        rd(12'h344, v); check("R3 cleared by compare", v, 0);
        strobe(0, 0, 32'h40, a, tgt); check("R5 no trap without pending", {28'd0, a}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule